// File: doc/BRIEF.md
# Disk Read/Write Gate Controller

This block sits between a disk controller and the head electronics of a drive. Three command bits select write, read and erase. The block registers them into a write gate, a read gate and an active-low erase gate, and gives the write path priority over the read path. The erase gate opens only while a write is also commanded. The same registered gates drive the two line drivers that share one serial data pair. When writing, data arriving from the pair is passed to the write formatter. When reading, pulses from the read detector are driven back onto the pair. The block guarantees that at most one driver is ever enabled.

A destination cylinder register is loaded by a strobe. The register accepts only cylinders 0 to 202. A larger value is rejected, raises a one-cycle range flag and leaves the register unchanged. From the held cylinder the block derives a reduced-write-current control, which is high on cylinders 128 and above. All state changes on the rising clock edge, and a synchronous reset clears it.

Top module: `disk_gate_ctrl`

## Requirements
- R1: One clock edge after `cmd[0]` is sampled high, `write_gate`, `wr_drv_en` and `fmt_en` are high. One edge after it is sampled low, all three are low.
- R2: `read_gate`, `rd_drv_en` and `line_oe` are high one edge after `cmd[1]` is sampled high with `cmd[0]` low. Otherwise they are low.
- R3: `erase_gate_n` is low, one edge later, only when `cmd[2]` and `cmd[0]` are both sampled high. With `cmd[2]` high and `cmd[0]` low, it stays high.
- R4: When `cmd[0]` and `cmd[1]` are sampled high together, the write gate is asserted and the read gate and read driver stay low.
- R5: `wr_drv_en` and `rd_drv_en` are never high together.
- R6: A load with `cyl_in` at or below 202 sets `cyl_addr` to `cyl_in` one edge later, with `range_err` low.
- R7: A load with `cyl_in` above 202 leaves `cyl_addr` unchanged and sets `range_err` high for exactly the following cycle.
- R8: `cur_reduce` is high exactly when the held `cyl_addr` is greater than 127.
- R9: A synchronous reset sets all gates inactive (`erase_gate_n` high, the others low), both drivers off, `cyl_addr` to 0, and `cur_reduce` and `range_err` to 0.
- R10: Without a load strobe, `cyl_addr` and `cur_reduce` hold their values.
- R11: `fmt_data` equals `line_in` while the write driver is enabled and is 0 otherwise. `line_out` equals `rd_pulse` while the read driver is enabled and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd | input | 3 | Command bits: 0 write, 1 read, 2 erase |
| cyl_in | input | 8 | Cylinder address to load |
| cyl_load | input | 1 | Load strobe for the cylinder register |
| line_in | input | 1 | Serial data received from the shared pair |
| rd_pulse | input | 1 | Serial read data from the pulse generator |
| write_gate | output | 1 | Registered write gate |
| read_gate | output | 1 | Registered read gate, inhibited by write |
| erase_gate_n | output | 1 | Registered erase gate, active low |
| wr_drv_en | output | 1 | Write line driver enable |
| rd_drv_en | output | 1 | Read line driver enable |
| fmt_en | output | 1 | Write formatter enable |
| fmt_data | output | 1 | Data passed to the write formatter |
| line_oe | output | 1 | Output enable of the shared pair toward the controller |
| line_out | output | 1 | Read data driven onto the shared pair |
| cyl_addr | output | 8 | Held destination cylinder |
| cur_reduce | output | 1 | Reduced-write-current control |
| range_err | output | 1 | One-cycle flag for a rejected cylinder load |

## Verification
The gates, driver enables, cylinder register, current control and range flag are all due on the first rising edge after their inputs are sampled. The bench therefore drives inputs on the falling edge and compares just after the next rising edge. The data-steering outputs are combinational from the line inputs and the already-registered enables. They are checked at the same sampling point, with the line inputs held steady across the edge. The bench keeps its own copy of the expected cylinder and recomputes every expected value from the command bits and load history alone.

// File: rtl/disk_gate_pkg.sv
package disk_gate_pkg;

  localparam int CMD_W    = 3;
  localparam int BIT_WR   = 0;
  localparam int BIT_RD   = 1;
  localparam int BIT_ERS  = 2;

  typedef struct packed {
    logic wr;
    logic rd;
    logic ers;
  } gate_t;

  localparam gate_t GATE_IDLE = '{wr: 1'b0, rd: 1'b0, ers: 1'b0};

  // Command decode: write has priority; erase only alongside a write.
  function automatic gate_t gate_next_f(input logic [CMD_W-1:0] c);
    gate_t g;
    g.wr  = c[BIT_WR];
    g.rd  = c[BIT_RD] & ~c[BIT_WR];
    g.ers = c[BIT_ERS] & c[BIT_WR];
    return g;
  endfunction

  function automatic logic cyl_ok_f(input int unsigned v, input int unsigned top);
    return v <= top;
  endfunction

  function automatic logic cut_f(input int unsigned v, input int unsigned thresh);
    return v > thresh;
  endfunction

endpackage

// File: rtl/gate_decode.sv
module gate_decode
  import disk_gate_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [CMD_W-1:0] cmd,
  output gate_t            gate_q
);

  gate_t gate_d;

  always_comb begin
    gate_d = gate_next_f(cmd);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q <= GATE_IDLE;
    end else begin
      gate_q <= gate_d;
    end
  end

endmodule

// File: rtl/cyl_addr_reg.sv
module cyl_addr_reg
  import disk_gate_pkg::*;
#(
  parameter int CYL_W      = 8,
  parameter int CYL_MAX    = 202,
  parameter int CUT_THRESH = 127
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CYL_W-1:0] din,
  output logic [CYL_W-1:0] addr,
  output logic             cut,
  output logic             bad,
  output logic             load_ok,
  output logic             load_bad
);

  localparam int unsigned TOP_U = CYL_MAX;
  localparam int unsigned THR_U = CUT_THRESH;

  logic din_ok;

  always_comb begin
    din_ok   = cyl_ok_f(int'(din), TOP_U);
    load_ok  = load & din_ok;
    load_bad = load & ~din_ok;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
      cut  <= 1'b0;
      bad  <= 1'b0;
    end else begin
      bad <= load_bad;
      if (load_ok) begin
        addr <= din;
        cut  <= cut_f(int'(din), THR_U);
      end
    end
  end

endmodule

// File: rtl/line_steer.sv
module line_steer
  import disk_gate_pkg::*;
(
  input  gate_t gate_q,
  input  logic  line_in,
  input  logic  rd_pulse,
  output logic  wr_drv_en,
  output logic  rd_drv_en,
  output logic  fmt_en,
  output logic  fmt_data,
  output logic  line_oe,
  output logic  line_out
);

  always_comb begin
    wr_drv_en = gate_q.wr;
    rd_drv_en = gate_q.rd & ~gate_q.wr;
    fmt_en    = wr_drv_en;
    fmt_data  = line_in & wr_drv_en;
    line_oe   = rd_drv_en;
    line_out  = rd_pulse & rd_drv_en;
  end

endmodule

// File: rtl/disk_gate_ctrl.sv
module disk_gate_ctrl
  import disk_gate_pkg::*;
#(
  parameter int CYL_W      = 8,
  parameter int CYL_MAX    = 202,
  parameter int CUT_THRESH = 127
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       cmd,
  input  logic [CYL_W-1:0] cyl_in,
  input  logic             cyl_load,
  input  logic             line_in,
  input  logic             rd_pulse,
  output logic             write_gate,
  output logic             read_gate,
  output logic             erase_gate_n,
  output logic             wr_drv_en,
  output logic             rd_drv_en,
  output logic             fmt_en,
  output logic             fmt_data,
  output logic             line_oe,
  output logic             line_out,
  output logic [CYL_W-1:0] cyl_addr,
  output logic             cur_reduce,
  output logic             range_err
);

  gate_t gate_q;
  logic  ev_load_ok;
  logic  ev_load_bad;

  gate_decode u_dec (
    .clk    (clk),
    .rst    (rst),
    .cmd    (cmd),
    .gate_q (gate_q)
  );

  cyl_addr_reg #(
    .CYL_W      (CYL_W),
    .CYL_MAX    (CYL_MAX),
    .CUT_THRESH (CUT_THRESH)
  ) u_cyl (
    .clk      (clk),
    .rst      (rst),
    .load     (cyl_load),
    .din      (cyl_in),
    .addr     (cyl_addr),
    .cut      (cur_reduce),
    .bad      (range_err),
    .load_ok  (ev_load_ok),
    .load_bad (ev_load_bad)
  );

  line_steer u_steer (
    .gate_q    (gate_q),
    .line_in   (line_in),
    .rd_pulse  (rd_pulse),
    .wr_drv_en (wr_drv_en),
    .rd_drv_en (rd_drv_en),
    .fmt_en    (fmt_en),
    .fmt_data  (fmt_data),
    .line_oe   (line_oe),
    .line_out  (line_out)
  );

  assign write_gate   = gate_q.wr;
  assign read_gate    = gate_q.rd;
  assign erase_gate_n = ~gate_q.ers;

endmodule

// File: rtl/disk_gate_checks.sv
module disk_gate_checks #(
  parameter int CYL_W      = 8,
  parameter int CYL_MAX    = 202,
  parameter int CUT_THRESH = 127
) (
  input logic             clk,
  input logic             rst,
  input logic [2:0]       cmd,
  input logic [CYL_W-1:0] cyl_in,
  input logic             cyl_load,
  input logic             write_gate,
  input logic             read_gate,
  input logic             erase_gate_n,
  input logic             wr_drv_en,
  input logic             rd_drv_en,
  input logic [CYL_W-1:0] cyl_addr,
  input logic             cur_reduce,
  input logic             range_err,
  input logic             ev_load_ok,
  input logic             ev_load_bad
);

  a_r1_write_follows: assert property (@(posedge clk) disable iff (rst)
    cmd[0] |=> (write_gate && wr_drv_en));

  a_r2_read_follows: assert property (@(posedge clk) disable iff (rst)
    (cmd[1] && !cmd[0]) |=> (read_gate && rd_drv_en));

  a_r3_erase_needs_write: assert property (@(posedge clk) disable iff (rst)
    !cmd[0] |=> erase_gate_n);

  a_r4_write_wins: assert property (@(posedge clk) disable iff (rst)
    cmd[0] |=> !read_gate);

  a_r5_one_driver: assert property (@(posedge clk) disable iff (rst)
    !(wr_drv_en && rd_drv_en));

  a_r6_load_takes: assert property (@(posedge clk) disable iff (rst)
    ev_load_ok |=> (cyl_addr == $past(cyl_in)) && !range_err);

  a_r7_reject_holds: assert property (@(posedge clk) disable iff (rst)
    ev_load_bad |=> ($stable(cyl_addr) && range_err));

  a_r7_bad_input: assert property (@(posedge clk) disable iff (rst)
    ev_load_bad |-> (cyl_load && (int'(cyl_in) > CYL_MAX)));

  a_r8_cut_matches: assert property (@(posedge clk) disable iff (rst)
    cur_reduce == (int'(cyl_addr) > CUT_THRESH));

  a_r9_reset_idle: assert property (@(posedge clk)
    rst |=> (!write_gate && !read_gate && erase_gate_n && !range_err && cyl_addr == '0));

  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !cyl_load |=> ($stable(cyl_addr) && $stable(cur_reduce)));

endmodule

bind disk_gate_ctrl disk_gate_checks #(
  .CYL_W      (CYL_W),
  .CYL_MAX    (CYL_MAX),
  .CUT_THRESH (CUT_THRESH)
) u_checks (
  .clk          (clk),
  .rst          (rst),
  .cmd          (cmd),
  .cyl_in       (cyl_in),
  .cyl_load     (cyl_load),
  .write_gate   (write_gate),
  .read_gate    (read_gate),
  .erase_gate_n (erase_gate_n),
  .wr_drv_en    (wr_drv_en),
  .rd_drv_en    (rd_drv_en),
  .cyl_addr     (cyl_addr),
  .cur_reduce   (cur_reduce),
  .range_err    (range_err),
  .ev_load_ok   (ev_load_ok),
  .ev_load_bad  (ev_load_bad)
);

// File: tb/sim_disk_gate_ctrl.sv
module sim_disk_gate_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYC    = 20000;

  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] cmd;
  logic [7:0] cyl_in;
  logic       cyl_load;
  logic       line_in;
  logic       rd_pulse;
  logic       write_gate, read_gate, erase_gate_n;
  logic       wr_drv_en, rd_drv_en, fmt_en, fmt_data, line_oe, line_out;
  logic [7:0] cyl_addr;
  logic       cur_reduce, range_err;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  logic [7:0] exp_cyl;

  always #(CLK_PERIOD/2) clk = ~clk;

  disk_gate_ctrl u0 (
    .clk(clk), .rst(rst), .cmd(cmd), .cyl_in(cyl_in), .cyl_load(cyl_load),
    .line_in(line_in), .rd_pulse(rd_pulse),
    .write_gate(write_gate), .read_gate(read_gate), .erase_gate_n(erase_gate_n),
    .wr_drv_en(wr_drv_en), .rd_drv_en(rd_drv_en), .fmt_en(fmt_en),
    .fmt_data(fmt_data), .line_oe(line_oe), .line_out(line_out),
    .cyl_addr(cyl_addr), .cur_reduce(cur_reduce), .range_err(range_err)
  );

  function automatic bit want_wr(input logic [2:0] c);
    return c[0] == 1'b1;
  endfunction

  function automatic bit want_rd(input logic [2:0] c);
    return (c == 3'b010) || (c == 3'b110);
  endfunction

  function automatic bit want_ers_n(input logic [2:0] c);
    return !(c[2] == 1'b1 && c[0] == 1'b1);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // Apply one cycle of stimulus, then check every output after the edge.
  task automatic step(input logic [2:0] c, input logic ld, input logic [7:0] v,
                      input logic li, input logic rp);
    bit bad;
    @(negedge clk);
    cmd = c; cyl_load = ld; cyl_in = v; line_in = li; rd_pulse = rp;
    bad = ld && (v > 8'd202);
    if (ld && !bad) exp_cyl = v;
    @(posedge clk);
    #1;
    chk("R1 write_gate", int'(write_gate), int'(want_wr(c)));
    chk("R1 fmt_en", int'(fmt_en), int'(want_wr(c)));
    chk("R2 read_gate", int'(read_gate), int'(want_rd(c)));
    chk("R2 line_oe", int'(line_oe), int'(want_rd(c)));
    chk("R3 erase_gate_n", int'(erase_gate_n), int'(want_ers_n(c)));
    if (c[0] && c[1]) chk("R4 rd_drv_en", int'(rd_drv_en), 0);
    chk("R5 drivers", int'(wr_drv_en && rd_drv_en), 0);
    chk("R6 cyl_addr", int'(cyl_addr), int'(exp_cyl));
    chk("R7 range_err", int'(range_err), int'(bad));
    chk("R8 cur_reduce", int'(cur_reduce), int'(exp_cyl >= 8'd128));
    chk("R11 fmt_data", int'(fmt_data), int'(li && want_wr(c)));
    chk("R11 line_out", int'(line_out), int'(rp && want_rd(c)));
  endtask

  initial begin : watchdog
    while (!done && cyc < MAX_CYC) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cyc, MAX_CYC);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] held;
    void'($urandom(32'd7901));
    rst = 1'b1; cmd = 3'b111; cyl_in = 8'd0; cyl_load = 1'b0;
    line_in = 1'b1; rd_pulse = 1'b1;
    exp_cyl = 8'd0;
    repeat (2) @(posedge clk);
    #1;
    chk("R9 write_gate", int'(write_gate), 0);
    chk("R9 read_gate", int'(read_gate), 0);
    chk("R9 erase_gate_n", int'(erase_gate_n), 1);
    chk("R9 drivers", int'(wr_drv_en || rd_drv_en), 0);
    chk("R9 cyl_addr", int'(cyl_addr), 0);
    chk("R9 cur_reduce", int'(cur_reduce), 0);
    @(negedge clk); rst = 1'b0;

    // Directed command corners: R1 R2 R3 R4
    step(3'b001, 1'b0, 8'd0, 1'b1, 1'b1);
    step(3'b100, 1'b0, 8'd0, 1'b1, 1'b1);
    step(3'b101, 1'b0, 8'd0, 1'b0, 1'b1);
    step(3'b011, 1'b0, 8'd0, 1'b1, 1'b1);
    step(3'b111, 1'b0, 8'd0, 1'b1, 1'b1);
    step(3'b010, 1'b0, 8'd0, 1'b1, 1'b1);
    step(3'b110, 1'b0, 8'd0, 1'b1, 0);
    step(3'b000, 1'b0, 8'd0, 1'b1, 1'b1);

    // Cylinder boundaries: R6 R7 R8
    step(3'b000, 1'b1, 8'd127, 1'b0, 1'b0);
    step(3'b000, 1'b1, 8'd128, 1'b0, 1'b0);
    step(3'b000, 1'b1, 8'd202, 1'b0, 1'b0);
    step(3'b000, 1'b1, 8'd203, 1'b0, 1'b0);
    chk("R7 unchanged after 203", int'(cyl_addr), 202);
    step(3'b000, 1'b1, 8'd255, 1'b0, 1'b0);
    step(3'b000, 1'b0, 8'd5, 1'b0, 1'b0);
    chk("R7 flag lasts one cycle", int'(range_err), 0);
    // R10: strobe low, new value on cyl_in ignored
    held = cyl_addr;
    step(3'b001, 1'b0, 8'd10, 1'b0, 1'b0);
    chk("R10 hold", int'(cyl_addr), int'(held));
    step(3'b000, 1'b1, 8'd0, 1'b0, 1'b0);

    // Random mix
    for (int i = 0; i < 600; i++) begin
      step(3'($urandom), ($urandom % 4) == 0, 8'($urandom),
           1'($urandom), 1'($urandom));
    end

    // Reset in mid-operation: R9
    step(3'b101, 1'b1, 8'd180, 1'b1, 1'b1);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    chk("R9 mid reset write", int'(write_gate), 0);
    chk("R9 mid reset erase_n", int'(erase_gate_n), 1);
    chk("R9 mid reset cyl", int'(cyl_addr), 0);
    chk("R9 mid reset cut", int'(cur_reduce), 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule